// File: doc/BRIEF.md
# Pending Interrupt Priority Selector

This block looks over a small bank of list-register entries, each describing one virtual interrupt, and picks the single entry that should be delivered next. An entry can win only if it lies inside the part of the bank that is in use, is in the plain pending state, and belongs to an interrupt group that is currently enabled. Among those, the one with the numerically lowest priority value wins, and on a tie the lower index wins.

The whole bank is presented as one packed vector, together with the number of entries in use and the two group enables. The choice is made combinationally and captured in one output register stage. The registered result gives a found flag, the winning index, the complete 64-bit entry and its priority field. When no entry qualifies, the output word carries the spurious interrupt ID 1023 in place of an entry.

Top module: `irq_pick_top`

## Requirements
- R1: Outputs are registered. They reflect the inputs sampled at the preceding rising clock edge. While reset is high they are found=0, index 0, priority 0xFF and word 1023.
- R2: Only entries whose index is below `used_cnt` are considered. A count of 16 or more makes all 16 entries eligible. Entries at or above the count are ignored whatever they hold.
- R3: The entry state field is bits 63:62. An entry qualifies only when this field equals 2'b01 (pending). Invalid (00), active (10) and pending-and-active (11) entries are skipped.
- R4: The group bit is bit 60. An entry with this bit at 0 needs `grp0_en` high, and an entry with it at 1 needs `grp1_en` high.
- R5: The priority is bits 55:48. Among qualifying entries, the one with the lowest priority value is chosen.
- R6: When several qualifying entries share the lowest priority, the one with the lowest index is chosen.
- R7: The search starts from an idle value of 0xFF and accepts only strictly lower priorities, so an entry with priority 0xFF is never chosen.
- R8: When nothing qualifies: found=0, the word is 1023 zero-extended to 64 bits, the index is 0 and the priority is 0xFF.
- R9: When an entry is chosen: found=1, the index names it, the word is its full 64-bit content, and the priority output equals its bits 55:48.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lr_bank | input | 1024 | Packed entries; entry i occupies bits 64*i+63 : 64*i |
| used_cnt | input | 5 | Number of entries in use |
| grp0_en | input | 1 | Group-0 enable |
| grp1_en | input | 1 | Group-1 enable |
| found | output | 1 | An entry was chosen |
| sel_idx | output | 4 | Index of the chosen entry |
| sel_word | output | 64 | Chosen entry, or 1023 when none is chosen |
| sel_prio | output | 8 | Priority of the chosen entry, or 0xFF |

## Verification
A pseudo-random sweep runs every used-count value from 0 to 17, plus 31, under all four group-enable combinations. The bank contents are biased toward pending entries and a narrow range of priorities, so that ties and range cut-offs occur often. Together these separate errors in the count boundary, the state decode and the group gating. Directed cases then test each rule on its own. Equal priorities show whether the lower index wins. A bank full of 0xFF priorities must give the spurious result. A best entry sitting just past the count must be ignored. Active and pending-and-active entries with better priority than a pending one must lose. Outputs are also sampled just after an input change to show the one-cycle delay.

// File: rtl/irq_pick_pkg.sv
package irq_pick_pkg;

    localparam int LR_W      = 64;
    localparam int PRIO_W    = 8;
    localparam int PRIO_LSB  = 48;
    localparam int STATE_LSB = 62;
    localparam int GRP_BIT   = 60;

    localparam logic [PRIO_W-1:0] IDLE_PRIO = 8'hFF;
    localparam logic [LR_W-1:0]   SPUR_WORD = 64'd1023;

    typedef enum logic [1:0] {
        ST_INVALID = 2'b00,
        ST_PENDING = 2'b01,
        ST_ACTIVE  = 2'b10,
        ST_PEND_ACT = 2'b11
    } lr_state_e;

    typedef struct packed {
        logic              ok;
        logic [PRIO_W-1:0] prio;
    } qual_t;

    function automatic lr_state_e entry_state(input logic [LR_W-1:0] w);
        return lr_state_e'(w[STATE_LSB +: 2]);
    endfunction

    function automatic logic [PRIO_W-1:0] entry_prio(input logic [LR_W-1:0] w);
        return w[PRIO_LSB +: PRIO_W];
    endfunction

    function automatic logic entry_group(input logic [LR_W-1:0] w);
        return w[GRP_BIT];
    endfunction

endpackage

// File: rtl/irq_entry_qual.sv
module irq_entry_qual
    import irq_pick_pkg::*;
#(
    parameter int IDX   = 0,
    parameter int CNT_W = 5
) (
    input  logic [LR_W-1:0]  word,
    input  logic [CNT_W-1:0] used_cnt,
    input  logic             grp0_en,
    input  logic             grp1_en,
    output qual_t            qual
);
    localparam logic [CNT_W-1:0] IDX_V = CNT_W'(IDX);

    logic in_range;
    logic is_pending;
    logic grp_ok;

    always_comb begin
        in_range   = (used_cnt > IDX_V);
        is_pending = (entry_state(word) == ST_PENDING);
        grp_ok     = entry_group(word) ? grp1_en : grp0_en;
        qual.ok    = in_range && is_pending && grp_ok;
        qual.prio  = entry_prio(word);
    end

endmodule

// File: rtl/irq_prio_scan.sv
module irq_prio_scan
    import irq_pick_pkg::*;
#(
    parameter int N     = 16,
    parameter int IDX_W = 4
) (
    input  qual_t [N-1:0]      quals,
    output logic               found,
    output logic [IDX_W-1:0]   idx,
    output logic [PRIO_W-1:0]  prio
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        prio  = IDLE_PRIO;
        for (int i = 0; i < N; i++) begin
            if (quals[i].ok && (quals[i].prio < prio)) begin
                found = 1'b1;
                idx   = IDX_W'(i);
                prio  = quals[i].prio;
            end
        end
    end

endmodule

// File: rtl/irq_result_reg.sv
module irq_result_reg
    import irq_pick_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               found_d,
    input  logic [IDX_W-1:0]   idx_d,
    input  logic [LR_W-1:0]    word_d,
    input  logic [PRIO_W-1:0]  prio_d,
    output logic               found_q,
    output logic [IDX_W-1:0]   idx_q,
    output logic [LR_W-1:0]    word_q,
    output logic [PRIO_W-1:0]  prio_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            found_q <= 1'b0;
            idx_q   <= '0;
            word_q  <= SPUR_WORD;
            prio_q  <= IDLE_PRIO;
        end else begin
            found_q <= found_d;
            idx_q   <= idx_d;
            word_q  <= found_d ? word_d : SPUR_WORD;
            prio_q  <= found_d ? prio_d : IDLE_PRIO;
        end
    end

    // R7: a chosen entry never carries the idle priority
    a_r7_no_idle_prio: assert property (@(posedge clk) disable iff (rst)
        found_q |-> (prio_q != IDLE_PRIO));

    // R9: the reported priority matches the reported word
    a_r9_prio_matches_word: assert property (@(posedge clk) disable iff (rst)
        found_q |-> (word_q[PRIO_LSB +: PRIO_W] == prio_q));

    // R8: the spurious result has a fixed shape
    a_r8_spurious_shape: assert property (@(posedge clk) disable iff (rst)
        !found_q |-> (word_q == SPUR_WORD && idx_q == '0 && prio_q == IDLE_PRIO));

endmodule

// File: rtl/irq_pick_top.sv
module irq_pick_top
    import irq_pick_pkg::*;
#(
    parameter int N_ENTRIES = 16,
    parameter int CNT_W     = $clog2(N_ENTRIES + 1),
    parameter int IDX_W     = $clog2(N_ENTRIES)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [N_ENTRIES*LR_W-1:0] lr_bank,
    input  logic [CNT_W-1:0]          used_cnt,
    input  logic                      grp0_en,
    input  logic                      grp1_en,
    output logic                      found,
    output logic [IDX_W-1:0]          sel_idx,
    output logic [LR_W-1:0]           sel_word,
    output logic [PRIO_W-1:0]         sel_prio
);
    logic [LR_W-1:0]       words [N_ENTRIES];
    qual_t [N_ENTRIES-1:0] quals;

    for (genvar g = 0; g < N_ENTRIES; g++) begin : g_entry
        assign words[g] = lr_bank[g*LR_W +: LR_W];
        irq_entry_qual #(.IDX(g), .CNT_W(CNT_W)) u_qual (
            .word     (words[g]),
            .used_cnt (used_cnt),
            .grp0_en  (grp0_en),
            .grp1_en  (grp1_en),
            .qual     (quals[g])
        );
    end

    logic              found_d;
    logic [IDX_W-1:0]  idx_d;
    logic [PRIO_W-1:0] prio_d;
    logic [LR_W-1:0]   word_d;

    irq_prio_scan #(.N(N_ENTRIES), .IDX_W(IDX_W)) u_scan (
        .quals (quals),
        .found (found_d),
        .idx   (idx_d),
        .prio  (prio_d)
    );

    assign word_d = words[idx_d];

    irq_result_reg #(.IDX_W(IDX_W)) u_out (
        .clk     (clk),
        .rst     (rst),
        .found_d (found_d),
        .idx_d   (idx_d),
        .word_d  (word_d),
        .prio_d  (prio_d),
        .found_q (found),
        .idx_q   (sel_idx),
        .word_q  (sel_word),
        .prio_q  (sel_prio)
    );

    // R2: a chosen index lies below the count sampled with it
    a_r2_index_in_range: assert property (@(posedge clk) disable iff (rst)
        found |-> ((CNT_W+1)'(sel_idx) < (CNT_W+1)'($past(used_cnt))));

    // R3: a chosen word is in the plain pending state
    a_r3_pending_only: assert property (@(posedge clk) disable iff (rst)
        found |-> (sel_word[STATE_LSB +: 2] == 2'b01));

    // R4: a chosen word belongs to a group enabled when it was sampled
    a_r4_group_enabled: assert property (@(posedge clk) disable iff (rst)
        found |-> (sel_word[GRP_BIT] ? $past(grp1_en) : $past(grp0_en)));

endmodule

// File: tb/irq_pick_top_tb.sv
`timescale 1ns/1ps
module irq_pick_top_tb;

    localparam int N = 16;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [N*64-1:0] lr_bank = '0;
    logic [4:0]      used_cnt = '0;
    logic            grp0_en = 1'b0;
    logic            grp1_en = 1'b0;
    logic            found;
    logic [3:0]      sel_idx;
    logic [63:0]     sel_word;
    logic [7:0]      sel_prio;

    logic [63:0] ent [N];
    logic [63:0] rng = 64'h9E3779B97F4A7C15;
    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    irq_pick_top u_dut (
        .clk(clk), .rst(rst), .lr_bank(lr_bank), .used_cnt(used_cnt),
        .grp0_en(grp0_en), .grp1_en(grp1_en), .found(found),
        .sel_idx(sel_idx), .sel_word(sel_word), .sel_prio(sel_prio)
    );

    function automatic logic [63:0] next_rand();
        rng = rng ^ (rng << 13);
        rng = rng ^ (rng >> 7);
        rng = rng ^ (rng << 17);
        return rng;
    endfunction

    function automatic logic [63:0] mk_entry(logic [1:0] st, logic grp, logic [7:0] pr, logic [31:0] vid);
        logic [63:0] w;
        w = '0;
        w[63:62] = st;
        w[60] = grp;
        w[55:48] = pr;
        w[31:0] = vid;
        return w;
    endfunction

    task automatic pack_bank();
        for (int i = 0; i < N; i++) lr_bank[i*64 +: 64] = ent[i];
    endtask

    task automatic check(string req, logic ef, logic [3:0] ei, logic [63:0] ew, logic [7:0] ep);
        vectors++;
        if (found !== ef || sel_idx !== ei || sel_word !== ew || sel_prio !== ep) begin
            miscompares++;
            $display("FAIL %s: got found=%0b idx=%0d word=%h prio=%h, expected found=%0b idx=%0d word=%h prio=%h",
                     req, found, sel_idx, sel_word, sel_prio, ef, ei, ew, ep);
        end
    endtask

    // Expected result from the requirements: bits 63:62 state, bit 60 group, 55:48 priority
    task automatic apply_and_check(string req);
        logic       ef;
        logic [3:0] ei;
        logic [7:0] ep;
        logic [63:0] ew;
        ef = 1'b0; ei = 4'd0; ep = 8'hFF; ew = 64'd1023;
        for (int i = 0; i < N; i++) begin
            if (i < int'(used_cnt) && ent[i][63:62] == 2'b01 &&
                (ent[i][60] ? grp1_en : grp0_en) && ent[i][55:48] < ep) begin
                ef = 1'b1; ei = 4'(i); ep = ent[i][55:48]; ew = ent[i];
            end
        end
        pack_bank();
        @(negedge clk);
        check(req, ef, ei, ew, ep);
    endtask

    task automatic clear_bank();
        for (int i = 0; i < N; i++) ent[i] = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        clear_bank();
        repeat (3) @(negedge clk);
        // R1: reset state, even with a qualifying entry present
        ent[0] = mk_entry(2'b01, 1'b1, 8'h01, 32'd5);
        pack_bank(); used_cnt = 5'd16; grp0_en = 1'b1; grp1_en = 1'b1;
        @(negedge clk);
        check("R1", 1'b0, 4'd0, 64'd1023, 8'hFF);
        rst = 1'b0;
        clear_bank();
        apply_and_check("R8");

        // R1: one-cycle latency; outputs hold until the next edge
        ent[2] = mk_entry(2'b01, 1'b0, 8'h20, 32'd40);
        pack_bank();
        #1;
        check("R1", 1'b0, 4'd0, 64'd1023, 8'hFF);
        @(negedge clk);
        check("R1", 1'b1, 4'd2, ent[2], 8'h20);

        // R6: tie goes to lower index
        clear_bank();
        ent[7] = mk_entry(2'b01, 1'b1, 8'h10, 32'd70);
        ent[3] = mk_entry(2'b01, 1'b1, 8'h10, 32'd30);
        ent[12] = mk_entry(2'b01, 1'b0, 8'h10, 32'd120);
        apply_and_check("R6");
        check("R6", 1'b1, 4'd3, ent[3], 8'h10);

        // R7: priority 0xFF never wins
        clear_bank();
        for (int i = 0; i < N; i++) ent[i] = mk_entry(2'b01, i[0], 8'hFF, 32'(i));
        apply_and_check("R7");
        check("R7", 1'b0, 4'd0, 64'd1023, 8'hFF);
        ent[15] = mk_entry(2'b01, 1'b1, 8'hFE, 32'd99);
        apply_and_check("R5");
        check("R5", 1'b1, 4'd15, ent[15], 8'hFE);

        // R2: best entry just past the count is ignored
        clear_bank();
        ent[9] = mk_entry(2'b01, 1'b0, 8'h00, 32'd9);
        ent[8] = mk_entry(2'b01, 1'b0, 8'h80, 32'd8);
        used_cnt = 5'd9;
        apply_and_check("R2");
        check("R2", 1'b1, 4'd8, ent[8], 8'h80);
        used_cnt = 5'd10;
        apply_and_check("R2");
        used_cnt = 5'd31;
        apply_and_check("R2");

        // R3: active and pending+active entries lose despite better priority
        clear_bank();
        ent[0] = mk_entry(2'b10, 1'b1, 8'h01, 32'd1);
        ent[1] = mk_entry(2'b11, 1'b1, 8'h02, 32'd2);
        ent[2] = mk_entry(2'b00, 1'b1, 8'h03, 32'd3);
        ent[5] = mk_entry(2'b01, 1'b1, 8'h40, 32'd5);
        used_cnt = 5'd16;
        apply_and_check("R3");
        check("R3", 1'b1, 4'd5, ent[5], 8'h40);

        // R4: group gating
        clear_bank();
        ent[1] = mk_entry(2'b01, 1'b0, 8'h05, 32'd11);
        ent[4] = mk_entry(2'b01, 1'b1, 8'h06, 32'd44);
        grp0_en = 1'b0; grp1_en = 1'b1;
        apply_and_check("R4");
        check("R4", 1'b1, 4'd4, ent[4], 8'h06);
        grp0_en = 1'b1; grp1_en = 1'b0;
        apply_and_check("R4");
        check("R4", 1'b1, 4'd1, ent[1], 8'h05);
        grp0_en = 1'b0;
        apply_and_check("R8");

        // R9: sweep over counts, enables and biased random banks (also R2 R3 R4 R5 R6)
        for (int pat = 0; pat < 40; pat++) begin
            for (int i = 0; i < N; i++) begin
                logic [63:0] r;
                logic [1:0]  st;
                logic [7:0]  pr;
                r  = next_rand();
                st = r[0] ? 2'b01 : r[2:1];
                pr = r[3] ? {5'b0, r[6:4]} : r[15:8];
                ent[i] = mk_entry(st, r[16], pr, r[63:32]);
                ent[i][59:56] = r[20:17];
            end
            for (int c = 0; c < 19; c++) begin
                for (int ge = 0; ge < 4; ge++) begin
                    used_cnt = (c == 18) ? 5'd31 : 5'(c);
                    grp0_en = ge[0];
                    grp1_en = ge[1];
                    apply_and_check("R9");
                end
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule